// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the product of two unsigned WIDTH-bit operands one multiplier bit at a time. It needs only one WIDTH-bit adder. The multiplicand and the multiplier arrive over a single shared data input, each captured by its own load strobe while the unit is idle. A start pulse launches the run. The control then alternates between an add-decide step and a shift step. In the add-decide step the low multiplier bit chooses whether the multiplicand is added into the upper half of the partial product, and the adder carry is kept in a carry flip-flop. In the shift step the chain of carry, upper half and lower half moves right by one place. A down-counter, loaded with WIDTH-1 at start, ends the loop after WIDTH shifts.

The double-length result is shown on the product port. Its upper half is the accumulator and its lower half is the register that first held the multiplier. A busy flag covers the run. A done flag rises when the run ends and stays set until the next start. A parameter selects the state encoding of the hardwired sequencer: either a two-bit binary code with a decoder, or one flip-flop per state. Both choices give the same behaviour at the ports.

Top module: `shift_add_mult`

## Requirements
- R1: After reset, busy and done are 0 and product is all zeros.
- R2: While idle, a cycle with ld_mcand high captures din as the multiplicand, and a cycle with ld_mplier high captures din into the lower half of product (product[WIDTH-1:0]), visible on the next cycle.
- R3: A cycle with go high while idle makes busy 1 and done 0 from the next cycle, with the accumulator and carry cleared so the run starts from a zero partial product.
- R4: busy stays high for exactly 2*WIDTH consecutive cycles per run (one add-decide and one shift cycle for each multiplier bit).
- R5: When busy falls, product equals the multiplicand times the multiplier as an unsigned 2*WIDTH-bit value, including zero and all-ones operands.
- R6: done is 1 from the cycle busy falls until the next accepted go.
- R7: ld_mcand, ld_mplier and go have no effect while busy: the running product finishes with the operands loaded before the start.
- R8: The add-decide state always moves to the shift state; the shift state returns to add-decide while the counter is nonzero and to idle when it is zero.
- R9: The carry flip-flop is zero after every shift step.
- R10: While idle with no load strobe and no go, product holds its value.
- R11: The binary-encoded sequencer (ONE_HOT=0) and the one-flip-flop-per-state sequencer (ONE_HOT=1) give identical busy, done and product sequences; exactly one state decode is active at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start request, accepted only while idle |
| din | input | WIDTH | Shared operand input |
| ld_mcand | input | 1 | Capture din as multiplicand (idle only) |
| ld_mplier | input | 1 | Capture din as multiplier (idle only) |
| busy | output | 1 | High while a multiplication runs |
| done | output | 1 | High after a run completes, until the next start |
| product | output | 2*WIDTH | Accumulator and multiplier register, high half first |

## Verification
The assertions assume that go and the load strobes are synchronous to clk and hold no X values after reset. They also assume that go is a level sampled once per cycle, so holding go high in idle restarts the unit at once after each run. The bench drives every input at the falling edge. It drops go one cycle after it is accepted and raises strobes during a run only on purpose, to show that they are ignored. Every operand pair of a four-bit configuration is swept through both sequencer encodings side by side.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_MUL0 = 2'b01;
  localparam logic [1:0] ST_MUL1 = 2'b10;

  function automatic int unsigned count_width(input int unsigned w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic zero,
  output logic st_idle,
  output logic st_mul0,
  output logic st_mul1
);
  import mul_pkg::*;

  generate
    if (ONE_HOT) begin : g_onehot
      logic [2:0] hot_q;
      logic [2:0] hot_d;
      always_comb begin
        hot_d[0] = (hot_q[0] & ~go) | (hot_q[2] & zero);
        hot_d[1] = (hot_q[0] & go) | (hot_q[2] & ~zero);
        hot_d[2] = hot_q[1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hot_q <= 3'b001;
        else        hot_q <= hot_d;
      end
      assign st_idle = hot_q[0];
      assign st_mul0 = hot_q[1];
      assign st_mul1 = hot_q[2];
    end else begin : g_binary
      logic [1:0] code_q;
      logic [1:0] code_d;
      always_comb begin
        code_d[1] = (code_q == ST_MUL0);
        code_d[0] = ((code_q == ST_IDLE) & go) | ((code_q == ST_MUL1) & ~zero);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= ST_IDLE;
        else        code_q <= code_d;
      end
      assign st_idle = (code_q == ST_IDLE);
      assign st_mul0 = (code_q == ST_MUL0);
      assign st_mul1 = (code_q == ST_MUL1);
    end
  endgenerate
endmodule

// File: rtl/mul_counter.sv
module mul_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic zero
);
  import mul_pkg::*;
  localparam int unsigned CW = count_width(WIDTH);
  localparam logic [CW-1:0] START = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (load)      cnt_q <= START;
    else if (dec)       cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             ld_b,
  input  logic             ld_q,
  input  logic             clr_acc,
  input  logic             add_en,
  input  logic             shift_en,
  output logic             q0,
  output logic             carry,
  output logic [WIDTH-1:0] acc,
  output logic [WIDTH-1:0] mq
);
  localparam int unsigned CHAIN = 2 * WIDTH + 1;

  logic [WIDTH-1:0] b_q;
  logic [WIDTH:0]   sum;
  logic [CHAIN-1:0] shifted;

  function automatic logic [WIDTH:0] add_step(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [CHAIN-1:0] shift_step(input logic c,
                                                  input logic [WIDTH-1:0] hi,
                                                  input logic [WIDTH-1:0] lo);
    return {c, hi, lo} >> 1;
  endfunction

  assign sum     = add_step(acc, b_q);
  assign shifted = shift_step(carry, acc, mq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_q <= '0;
    else if (ld_b) b_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry <= 1'b0;
      acc   <= '0;
    end else if (clr_acc) begin
      carry <= 1'b0;
      acc   <= '0;
    end else if (add_en) begin
      carry <= sum[WIDTH];
      acc   <= sum[WIDTH-1:0];
    end else if (shift_en) begin
      carry <= shifted[CHAIN-1];
      acc   <= shifted[CHAIN-2:WIDTH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mq <= '0;
    else if (ld_q)     mq <= din;
    else if (shift_en) mq <= shifted[WIDTH-1:0];
  end

  assign q0 = mq[0];
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          ONE_HOT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [WIDTH-1:0]   din,
  input  logic               ld_mcand,
  input  logic               ld_mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic st_idle, st_mul0, st_mul1;
  logic zero, q0, carry;
  logic ev_start, ev_add, ev_shift, ev_finish;
  logic ld_b_en, ld_q_en;
  logic [WIDTH-1:0] acc, mq;

  mul_ctrl #(.ONE_HOT(ONE_HOT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .zero(zero),
    .st_idle(st_idle), .st_mul0(st_mul0), .st_mul1(st_mul1)
  );

  assign ev_start  = st_idle & go;
  assign ev_add    = st_mul0 & q0;
  assign ev_shift  = st_mul1;
  assign ev_finish = st_mul1 & zero;
  assign ld_b_en   = st_idle & ld_mcand;
  assign ld_q_en   = st_idle & ld_mplier;

  mul_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ev_start), .dec(ev_shift), .zero(zero)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .din(din), .ld_b(ld_b_en), .ld_q(ld_q_en),
    .clr_acc(ev_start), .add_en(ev_add), .shift_en(ev_shift),
    .q0(q0), .carry(carry), .acc(acc), .mq(mq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done <= 1'b0;
    else if (ev_start)  done <= 1'b0;
    else if (ev_finish) done <= 1'b1;
  end

  assign busy    = ~st_idle;
  assign product = {acc, mq};
endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               go,
  input logic               ld_mcand,
  input logic               ld_mplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product,
  input logic               st_idle,
  input logic               st_mul0,
  input logic               st_mul1,
  input logic               zero,
  input logic               carry
);
  logic [31:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= '0;
  end

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> (busy && !done));
  assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 2 * WIDTH));
  assert_done_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_add_to_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_mul0 |=> st_mul1);
  assert_loop_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mul1 && !zero) |=> st_mul0);
  assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mul1 && zero) |=> st_idle);
  assert_carry_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_mul1 |=> (carry == 1'b0));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go && !ld_mcand && !ld_mplier) |=> $stable(product));
  assert_one_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_idle, st_mul0, st_mul1}));
endmodule

bind shift_add_mult mul_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .ld_mcand(ld_mcand), .ld_mplier(ld_mplier),
  .busy(busy), .done(done), .product(product),
  .st_idle(st_idle), .st_mul0(st_mul0), .st_mul1(st_mul1),
  .zero(zero), .carry(carry)
);

// File: tb/tb_shift_add_mult.sv
`timescale 1ns/1ps
module tb_shift_add_mult;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic ld_mcand = 1'b0;
  logic ld_mplier = 1'b0;
  logic [W-1:0] din = '0;
  logic busy, done, busy_oh, done_oh;
  logic [2*W-1:0] product, product_oh;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  shift_add_mult #(.WIDTH(W), .ONE_HOT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .din(din), .ld_mcand(ld_mcand),
    .ld_mplier(ld_mplier), .busy(busy), .done(done), .product(product)
  );

  shift_add_mult #(.WIDTH(W), .ONE_HOT(1'b1)) dut_oh (
    .clk(clk), .rst_n(rst_n), .go(go), .din(din), .ld_mcand(ld_mcand),
    .ld_mplier(ld_mplier), .busy(busy_oh), .done(done_oh), .product(product_oh)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_match(input string req);
    check({busy_oh, done_oh, product_oh} == {busy, done, product}, req,
          {busy_oh, done_oh, product_oh}, {busy, done, product});
  endtask

  task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
    logic [2*W-1:0] expect_p;
    logic [2*W-1:0] held;
    expect_p = (2*W)'(int'(a) * int'(b));
    ld_mcand = 1'b1; din = a;
    @(negedge clk);
    ld_mcand = 1'b0; ld_mplier = 1'b1; din = b;
    @(negedge clk);
    ld_mplier = 1'b0;
    check(product[W-1:0] == b, "R2 multiplier load", product[W-1:0], b);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R3 start", {busy, done}, 2'b10);
    check(product[2*W-1:W] == '0, "R3 accumulator cleared", product[2*W-1:W], 0);
    for (int k = 2; k <= 2*W; k++) begin
      if (disturb && k == 3) begin
        go = 1'b1; ld_mcand = 1'b1; ld_mplier = 1'b1; din = ~b;
      end else begin
        go = 1'b0; ld_mcand = 1'b0; ld_mplier = 1'b0;
      end
      @(negedge clk);
    end
    go = 1'b0; ld_mcand = 1'b0; ld_mplier = 1'b0;
    check(busy == 1'b1, "R4 busy through last cycle", busy, 1);
    check_match("R11 encodings agree mid-run");
    @(negedge clk);
    check(busy == 1'b0, "R4 busy ends after 2*WIDTH cycles", busy, 0);
    check(done == 1'b1, "R6 done set", done, 1);
    if (disturb)
      check(product == expect_p, "R7 strobes ignored while busy", product, expect_p);
    else
      check(product == expect_p, "R5 product", product, expect_p);
    check_match("R11 encodings agree at end");
    held = product;
    repeat (2) @(negedge clk);
    check(product == held && done == 1'b1, "R10 idle hold / R6 done held",
          {done, product}, {1'b1, held});
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 reset state",
          {busy, done, product}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 after release",
          {busy, done, product}, 0);
    // R5 R7 R8 R9: full operand sweep including 0 and all-ones corners
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_mult(W'(a), W'(b), ((a + b) % 7) == 0);
      end
    end
    // R6: done drops on the next accepted start
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(done == 1'b0 && busy == 1'b1, "R6 done cleared by start", {busy, done}, 2'b10);
    repeat (2*W) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R6 done after restart", {busy, done}, 2'b01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule